// File: doc/BRIEF.md
# Bus Status Command Decoder

This block sits beside a processor that announces each bus cycle with a 3-bit status code on dedicated status lines. The code 111 means the bus is passive. Any other value identifies the kind of cycle that is about to run. The block watches these lines, detects the moment a cycle begins, and decodes which cycle it is. It then drives the command strobes for memory, I/O and interrupt acknowledge, each at the proper clock.

Alongside the commands, the block produces three control signals:
- an address strobe, for latching the address externally;
- a data-enable that frames the data phase of the cycle;
- a direction signal that steers the data transceivers.

A global enable input can silence every command strobe without disturbing the cycle tracking. By default the command strobes are active low.

Top module: `bus_cmd_decoder`

## Requirements
- R1: While reset is held and in the clock after it is released with status 111, all seven command outputs are high, addr_strobe_o is 0, data_en_o is 0 and xmit_dir_o is 1.
- R2: A cycle starts only at a clock edge where status is sampled as not 111 and the value sampled at the previous edge was 111. The status sampled before the first edge after reset counts as not 111. addr_strobe_o is 1 for exactly the one clock following the start edge (the address phase).
- R3: In the data phase, the status code decides which commands are low. 000 drives intack_cmd_o. 001 drives iord_cmd_o. 010 drives iowr_cmd_o. 100 and 101 both drive memrd_cmd_o. 110 drives memwr_cmd_o. No other command is low.
- R4: The early write strobes go low in the address phase and stay low through the data phase, one clock before the matching normal write strobe. memwr_early_cmd_o goes with code 110 and iowr_early_cmd_o goes with code 010.
- R5: The data phase begins in the clock after the address phase. Its commands stay low for as long as the status stays away from 111.
- R6: When status 111 is sampled at an edge during a cycle, every command output goes high and data_en_o goes to 0 in the following clock. This also applies when the cycle is still in its address phase.
- R7: xmit_dir_o is 0 during the address and data phases of codes 000, 001, 100 and 101, and 1 at all other times.
- R8: data_en_o is 1 during the data phase of every code except 011, and 0 otherwise.
- R9: While cmd_en is 0, all seven command outputs are high in that same clock. addr_strobe_o, data_en_o, xmit_dir_o and the cycle tracking are unaffected, so the commands return as soon as cmd_en is 1 again.
- R10: A change of status from one non-111 code to another, without passing through 111, is ignored: the commands of the running cycle persist.
- R11: Code 011 (halt) produces the address strobe but no command and no data enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_en | input | 1 | Command enable; 0 forces all commands inactive |
| stat_i | input | STAT_W (3) | Status code from the processor |
| addr_strobe_o | output | 1 | Address latch strobe, high for the address phase |
| data_en_o | output | 1 | Data transceiver enable, high in the data phase |
| xmit_dir_o | output | 1 | Transceiver direction: 1 transmit, 0 receive |
| memrd_cmd_o | output | 1 | Memory read command |
| memwr_cmd_o | output | 1 | Memory write command |
| memwr_early_cmd_o | output | 1 | Early memory write command |
| iord_cmd_o | output | 1 | I/O read command |
| iowr_cmd_o | output | 1 | I/O write command |
| iowr_early_cmd_o | output | 1 | Early I/O write command |
| intack_cmd_o | output | 1 | Interrupt acknowledge command |

## Verification
The hardest situations to reach are those where the status code misbehaves relative to the cycle: switching between two active codes with no passive gap, and returning to passive while the cycle is still in its address phase. The stimulus reaches both by moving the status lines on a falling edge chosen by phase count after a cycle start. It then checks that the running command persists in the first case, and that the early strobe is withdrawn and no normal strobe appears in the second. A reset released while the status already shows an active code is also driven, to confirm that no cycle is started without a passive value first.

// File: rtl/bcd_pkg.sv
`timescale 1ns/1ps
package bcd_pkg;

   typedef enum logic [2:0] {
      ST_INTA  = 3'b000,
      ST_IORD  = 3'b001,
      ST_IOWR  = 3'b010,
      ST_HALT  = 3'b011,
      ST_FETCH = 3'b100,
      ST_MEMRD = 3'b101,
      ST_MEMWR = 3'b110,
      ST_IDLE  = 3'b111
   } bus_stat_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2
   } phase_e;

   localparam int NUM_CMD     = 7;
   localparam int CMD_MEMRD   = 0;
   localparam int CMD_MEMWR   = 1;
   localparam int CMD_MEMWR_E = 2;
   localparam int CMD_IORD    = 3;
   localparam int CMD_IOWR    = 4;
   localparam int CMD_IOWR_E  = 5;
   localparam int CMD_INTACK  = 6;

   typedef struct packed {
      logic [NUM_CMD-1:0] normal;  // asserted in the data phase
      logic [NUM_CMD-1:0] early;   // asserted from the address phase on
      logic               rx;      // data flows toward the processor
      logic               xfer;    // cycle has a data phase
   } cmd_plan_t;

   function automatic cmd_plan_t plan_for(bus_stat_e k);
      cmd_plan_t p;
      p      = '0;
      p.xfer = 1'b1;
      unique case (k)
         ST_INTA:  begin p.normal[CMD_INTACK] = 1'b1; p.rx = 1'b1; end
         ST_IORD:  begin p.normal[CMD_IORD]   = 1'b1; p.rx = 1'b1; end
         ST_IOWR:  begin p.normal[CMD_IOWR]   = 1'b1; p.early[CMD_IOWR_E]  = 1'b1; end
         ST_FETCH: begin p.normal[CMD_MEMRD]  = 1'b1; p.rx = 1'b1; end
         ST_MEMRD: begin p.normal[CMD_MEMRD]  = 1'b1; p.rx = 1'b1; end
         ST_MEMWR: begin p.normal[CMD_MEMWR]  = 1'b1; p.early[CMD_MEMWR_E] = 1'b1; end
         default:  p.xfer = 1'b0;   // halt and passive
      endcase
      return p;
   endfunction

endpackage

// File: rtl/bcd_tracker.sv
`timescale 1ns/1ps
module bcd_tracker
   import bcd_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2:0]      stat_i,
   output phase_e          phase_o,
   output bus_stat_e       kind_o
);

   bus_stat_e prev_q;
   bus_stat_e kind_q;
   phase_e    ph_q;
   bus_stat_e stat_now;
   logic      passive_now;

   assign stat_now    = bus_stat_e'(stat_i);
   assign passive_now = (stat_now == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= ST_INTA;      // not passive: a passive value must be seen first
         kind_q <= ST_IDLE;
         ph_q   <= PH_IDLE;
      end else begin
         prev_q <= stat_now;
         unique case (ph_q)
            PH_IDLE: begin
               if (prev_q == ST_IDLE && !passive_now) begin
                  ph_q   <= PH_ADDR;
                  kind_q <= stat_now;
               end
            end
            PH_ADDR: begin
               if (passive_now) begin
                  ph_q   <= PH_IDLE;
                  kind_q <= ST_IDLE;
               end else begin
                  ph_q   <= PH_DATA;
               end
            end
            PH_DATA: begin
               if (passive_now) begin
                  ph_q   <= PH_IDLE;
                  kind_q <= ST_IDLE;
               end
            end
            default: begin
               ph_q   <= PH_IDLE;
               kind_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign phase_o = ph_q;
   assign kind_o  = kind_q;

endmodule

// File: rtl/bcd_cmd_map.sv
`timescale 1ns/1ps
module bcd_cmd_map
   import bcd_pkg::*;
(
   input  phase_e               phase_i,
   input  bus_stat_e            kind_i,
   output logic [NUM_CMD-1:0]   cmd_act_o,
   output logic                 ale_o,
   output logic                 den_o,
   output logic                 tx_o
);

   cmd_plan_t plan;
   logic      in_cycle;
   logic      in_data;

   assign plan     = plan_for(kind_i);
   assign in_cycle = (phase_i != PH_IDLE);
   assign in_data  = (phase_i == PH_DATA);

   for (genvar i = 0; i < NUM_CMD; i++) begin : g_bit
      assign cmd_act_o[i] = (plan.normal[i] & in_data) | (plan.early[i] & in_cycle);
   end

   assign ale_o = (phase_i == PH_ADDR);
   assign den_o = in_data & plan.xfer;
   assign tx_o  = ~(in_cycle & plan.rx);

endmodule

// File: rtl/bcd_drive.sv
`timescale 1ns/1ps
module bcd_drive #(
   parameter int NUM        = 7,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic           en_i,
   input  logic [NUM-1:0] act_i,
   output logic [NUM-1:0] pin_o
);

   logic [NUM-1:0] gated;
   assign gated = act_i & {NUM{en_i}};

   if (ACTIVE_LOW) begin : g_low
      assign pin_o = ~gated;
   end else begin : g_high
      assign pin_o = gated;
   end

endmodule

// File: rtl/bus_cmd_decoder.sv
`timescale 1ns/1ps
module bus_cmd_decoder
   import bcd_pkg::*;
#(
   parameter int STAT_W         = 3,
   parameter bit CMD_ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_en,
   input  logic [STAT_W-1:0] stat_i,
   output logic              addr_strobe_o,
   output logic              data_en_o,
   output logic              xmit_dir_o,
   output logic              memrd_cmd_o,
   output logic              memwr_cmd_o,
   output logic              memwr_early_cmd_o,
   output logic              iord_cmd_o,
   output logic              iowr_cmd_o,
   output logic              iowr_early_cmd_o,
   output logic              intack_cmd_o
);

   localparam int CODE_W = $bits(bus_stat_e);

   if (STAT_W != CODE_W) begin : g_bad_width
      $error("bus_cmd_decoder: STAT_W must equal the status code width");
   end

   phase_e             phase;
   bus_stat_e          kind;
   logic [NUM_CMD-1:0] cmd_act;
   logic [NUM_CMD-1:0] cmd_pin;

   bcd_tracker u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .stat_i  (stat_i[CODE_W-1:0]),
      .phase_o (phase),
      .kind_o  (kind)
   );

   bcd_cmd_map u_map (
      .phase_i   (phase),
      .kind_i    (kind),
      .cmd_act_o (cmd_act),
      .ale_o     (addr_strobe_o),
      .den_o     (data_en_o),
      .tx_o      (xmit_dir_o)
   );

   bcd_drive #(.NUM(NUM_CMD), .ACTIVE_LOW(CMD_ACTIVE_LOW)) u_drive (
      .en_i  (cmd_en),
      .act_i (cmd_act),
      .pin_o (cmd_pin)
   );

   assign memrd_cmd_o       = cmd_pin[CMD_MEMRD];
   assign memwr_cmd_o       = cmd_pin[CMD_MEMWR];
   assign memwr_early_cmd_o = cmd_pin[CMD_MEMWR_E];
   assign iord_cmd_o        = cmd_pin[CMD_IORD];
   assign iowr_cmd_o        = cmd_pin[CMD_IOWR];
   assign iowr_early_cmd_o  = cmd_pin[CMD_IOWR_E];
   assign intack_cmd_o      = cmd_pin[CMD_INTACK];

endmodule

// File: rtl/bcd_chk.sv
`timescale 1ns/1ps
module bcd_chk #(
   parameter int STAT_W         = 3,
   parameter bit CMD_ACTIVE_LOW = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_en,
   input logic [STAT_W-1:0] stat_i,
   input logic              addr_strobe_o,
   input logic              data_en_o,
   input logic              xmit_dir_o,
   input logic              memrd_cmd_o,
   input logic              memwr_cmd_o,
   input logic              memwr_early_cmd_o,
   input logic              iord_cmd_o,
   input logic              iowr_cmd_o,
   input logic              iowr_early_cmd_o,
   input logic              intack_cmd_o
);

   logic [6:0] pins;
   logic [6:0] act;   // bit order: intack, iowr_e, iowr, iord, memwr_e, memwr, memrd
   assign pins = {intack_cmd_o, iowr_early_cmd_o, iowr_cmd_o, iord_cmd_o,
                  memwr_early_cmd_o, memwr_cmd_o, memrd_cmd_o};
   assign act  = CMD_ACTIVE_LOW ? ~pins : pins;

   // R2
   ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_strobe_o |=> !addr_strobe_o);

   // R2
   ale_after_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_strobe_o |-> ($past(stat_i) != 3'b111));

   // R4
   memwr_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_en && $past(cmd_en) && act[1]) |-> $past(act[2]));

   // R4
   iowr_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_en && $past(cmd_en) && act[4]) |-> $past(act[5]));

   // R6
   passive_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_i == 3'b111) |=> (act == 7'b0 && !data_en_o));

   // R7
   read_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act[0] || act[3] || act[6]) |-> !xmit_dir_o);

   // R7
   write_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act[1] || act[4]) |-> xmit_dir_o);

   // R9
   disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_en |-> (act == 7'b0));

   // R3
   cmd_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(act) <= 2);

endmodule

bind bus_cmd_decoder bcd_chk #(.STAT_W(STAT_W), .CMD_ACTIVE_LOW(CMD_ACTIVE_LOW)) u_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .cmd_en            (cmd_en),
   .stat_i            (stat_i),
   .addr_strobe_o     (addr_strobe_o),
   .data_en_o         (data_en_o),
   .xmit_dir_o        (xmit_dir_o),
   .memrd_cmd_o       (memrd_cmd_o),
   .memwr_cmd_o       (memwr_cmd_o),
   .memwr_early_cmd_o (memwr_early_cmd_o),
   .iord_cmd_o        (iord_cmd_o),
   .iowr_cmd_o        (iowr_cmd_o),
   .iowr_early_cmd_o  (iowr_early_cmd_o),
   .intack_cmd_o      (intack_cmd_o)
);

// File: tb/bus_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module bus_cmd_decoder_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_en = 1'b1;
   logic [2:0] stat = 3'b111;
   logic       ale, den, dtr;
   logic       memrd_n, memwr_n, memwr_e_n, iord_n, iowr_n, iowr_e_n, intack_n;
   int         n_cmp = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   bus_cmd_decoder dut_i (
      .clk               (clk),
      .rst_n             (rst_n),
      .cmd_en            (cmd_en),
      .stat_i            (stat),
      .addr_strobe_o     (ale),
      .data_en_o         (den),
      .xmit_dir_o        (dtr),
      .memrd_cmd_o       (memrd_n),
      .memwr_cmd_o       (memwr_n),
      .memwr_early_cmd_o (memwr_e_n),
      .iord_cmd_o        (iord_n),
      .iowr_cmd_o        (iowr_n),
      .iowr_early_cmd_o  (iowr_e_n),
      .intack_cmd_o      (intack_n)
   );

   // active-high view, bit order: intack, iowr_e, iowr, iord, memwr_e, memwr, memrd
   function automatic logic [6:0] cmds();
      return ~{intack_n, iowr_e_n, iowr_n, iord_n, memwr_e_n, memwr_n, memrd_n};
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // {code[18:16], data-phase cmds[15:9], addr-phase cmds[8:2], dir[1], den[0]}
   localparam logic [18:0] VEC [7] = '{
      {3'b000, 7'b1000000, 7'b0000000, 1'b0, 1'b1},
      {3'b001, 7'b0001000, 7'b0000000, 1'b0, 1'b1},
      {3'b010, 7'b0110000, 7'b0100000, 1'b1, 1'b1},
      {3'b011, 7'b0000000, 7'b0000000, 1'b1, 1'b0},
      {3'b100, 7'b0000001, 7'b0000000, 1'b0, 1'b1},
      {3'b101, 7'b0000001, 7'b0000000, 1'b0, 1'b1},
      {3'b110, 7'b0000110, 7'b0000100, 1'b1, 1'b1}
   };

   initial begin
      #500us;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      chk("R1 reset cmds", {1'b0, cmds()}, 8'h00);
      chk("R1 reset ale/den/dir", {5'b0, ale, den, dtr}, 8'h01);
      rst_n = 1'b1;
      tick();
      chk("R1 after release cmds", {1'b0, cmds()}, 8'h00);
      chk("R1 after release ale/den/dir", {5'b0, ale, den, dtr}, 8'h01);

      // table walk: one full cycle per code
      for (int i = 0; i < 7; i++) begin
         stat = VEC[i][18:16];
         tick();
         chk("R2 ale in address phase", {7'b0, ale}, 8'h01);
         chk("R4 address-phase cmds", {1'b0, cmds()}, {1'b0, VEC[i][8:2]});
         chk("R7 dir in address phase", {7'b0, dtr}, {7'b0, VEC[i][1]});
         chk("R8 den off in address phase", {7'b0, den}, 8'h00);
         tick();
         chk("R3 R11 data-phase cmds", {1'b0, cmds()}, {1'b0, VEC[i][15:9]});
         chk("R2 ale single clock", {7'b0, ale}, 8'h00);
         chk("R8 den in data phase", {7'b0, den}, {7'b0, VEC[i][0]});
         chk("R7 dir in data phase", {7'b0, dtr}, {7'b0, VEC[i][1]});
         tick();
         chk("R5 cmds held", {1'b0, cmds()}, {1'b0, VEC[i][15:9]});
         stat = 3'b111;
         tick();
         chk("R6 cmds released", {1'b0, cmds()}, 8'h00);
         chk("R6 den released", {7'b0, den}, 8'h00);
         chk("R7 dir idle", {7'b0, dtr}, 8'h01);
         tick();
      end

      // R9: enable gating mid-cycle
      stat = 3'b110;
      tick();
      tick();
      cmd_en = 1'b0;
      #1;
      chk("R9 cmds forced off", {1'b0, cmds()}, 8'h00);
      chk("R9 den unaffected", {7'b0, den}, 8'h01);
      tick();
      chk("R9 still off", {1'b0, cmds()}, 8'h00);
      cmd_en = 1'b1;
      #1;
      chk("R9 cmds return", {1'b0, cmds()}, 8'h06);
      stat = 3'b111;
      tick();
      tick();

      // R10: active-to-active change ignored
      stat = 3'b101;
      tick();
      tick();
      stat = 3'b110;
      tick();
      chk("R10 read persists", {1'b0, cmds()}, 8'h01);
      tick();
      chk("R10 read persists again", {1'b0, cmds()}, 8'h01);
      chk("R10 no addr strobe", {7'b0, ale}, 8'h00);
      stat = 3'b111;
      tick();
      chk("R6 end after change", {1'b0, cmds()}, 8'h00);
      tick();

      // R6: passive during address phase
      stat = 3'b010;
      tick();
      chk("R4 early io write", {1'b0, cmds()}, 8'h20);
      stat = 3'b111;
      tick();
      chk("R6 early end cmds", {1'b0, cmds()}, 8'h00);
      chk("R6 early end ale/den", {6'b0, ale, den}, 8'h00);
      tick();
      chk("R6 no late strobe", {1'b0, cmds()}, 8'h00);

      // R2: reset released with active status starts nothing
      rst_n = 1'b0;
      stat  = 3'b101;
      tick();
      tick();
      rst_n = 1'b1;
      tick();
      chk("R2 no start after reset", {7'b0, ale}, 8'h00);
      tick();
      chk("R2 no cmds after reset", {1'b0, cmds()}, 8'h00);
      stat = 3'b111;
      tick();
      stat = 3'b101;
      tick();
      chk("R2 start after passive", {7'b0, ale}, 8'h01);
      tick();
      chk("R3 read after restart", {1'b0, cmds()}, 8'h01);
      stat = 3'b111;
      tick();
      tick();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule